// File: doc/BRIEF.md
# Configurable-Aspect Single-Port RAM

A synchronous single-port memory built on one fixed array of 4096 bits. A parameter picks its shape: 16, 8, 4, 2 or 1 bits wide. The depth is 4096 divided by the width. The write data, the address, the lane enables and the write enable are captured in input registers on an input clock. Those registers load only while an input clock enable is high. A stall input keeps the captured address and lets the other input registers load as normal. A captured write goes into the array on the next input clock edge. Until then, the read path shows the word as it was before the write (read-before-write).

The read word passes to the output in one of two ways, chosen by a parameter. It can go through an output register on its own clock, with its own clock enable. Or it can go straight to the port as soon as the address register changes. A synchronous reset on the input clock clears only the captured address and the captured write enable. No register has an asynchronous clear, and the array contents are undefined until they are written.

Top module: `shape_ram`

## Requirements
- R1: With `DATA_W` set to 16, 8, 4, 2 or 1, the block stores 4096/`DATA_W` independent words, and each word reads back the value last written to it.
- R2: The input registers load only on an `in_clk` rising edge with `in_ce` = 1. With `in_ce` = 0, no write takes place and the captured address does not change, whatever `we`, `addr` and `wdata` are.
- R3: With `OUT_REG` = 1, `rdata` loads the word at the captured address on each `out_clk` rising edge with `out_ce` = 1. On an edge with `out_ce` = 0, `rdata` keeps its value.
- R4: On an enabled edge with `stall` = 1, the captured address keeps its previous value while data, lane enables and write enable still load. A write issued under stall goes to the held address.
- R5: In the 16-bit shape, `lane_en[0]` enables bits 7:0 and `lane_en[1]` enables bits 15:8. In the 8-bit shape, `lane_en[0]` enables the whole word. A lane whose enable is 0 keeps its old contents.
- R6: Each enabled edge with `we` = 1 causes exactly one write, committed on the following `in_clk` edge. Holding `in_ce` low afterwards neither repeats that write nor applies new `wdata`.
- R7: In the cycle after a write is captured, the read path shows the old contents of the addressed word. A read captured on the next enabled edge shows the new contents.
- R8: In the 4-, 2- and 1-bit shapes, `lane_en` has no effect and every write replaces the whole word.
- R9: With `OUT_REG` = 0, `rdata` shows the word at the captured address right after the `in_clk` edge, and `out_clk` and `out_ce` have no effect.
- R10: `rst` is sampled on `in_clk`. While it is high, the captured address is cleared to 0 and the captured write enable is cleared, so nothing is written. The array is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Clock for the input registers and the array |
| rst | input | 1 | Synchronous clear of the captured address and the write enable |
| in_ce | input | 1 | Clock enable for the input registers |
| stall | input | 1 | Keeps the captured address |
| we | input | 1 | Write request |
| addr | input | log2(4096/DATA_W) | Word address |
| wdata | input | DATA_W | Write data |
| lane_en | input | 2 if DATA_W=16, else 1 | Byte-lane write enables |
| out_clk | input | 1 | Clock for the output register |
| out_ce | input | 1 | Clock enable for the output register |
| rdata | output | DATA_W | Read data |

## Verification
**Checked by assertions on every cycle:**
- While `in_ce` is low, the captured address and data stay put, and no write is armed.
- Every enabled edge that has a write request arms exactly one write.
- `stall` keeps the captured address.
- A masked upper byte lane is left unchanged by a commit.
- A registered output holds its value while `out_ce` is low.

**Shown only by the bench scenarios:**
- Whole-memory fill-and-read sweeps of the 16-bit registered shape and the 4-bit bypass shape, run side by side.
- Read-before-write ordering.
- A write issued under stall landing at the held address.
- Reset suppressing a write.
- Narrow shapes ignoring the lane enables.
- A long random mix of enables, stalls and lane masks, checked against reference arrays kept in the bench.

// File: rtl/shape_ram_pkg.sv
package shape_ram_pkg;
    // One physical array: 256 rows of 16 bits, shared by every shape.
    localparam int TOTAL_BITS = 4096;
    localparam int ROW_W      = 16;
    localparam int ROWS       = TOTAL_BITS / ROW_W;
    localparam int ROW_AW     = $clog2(ROWS);
    localparam int LANE_BITS  = 8;

    // Lane-enable port width for a word width: 2 lanes at 16, otherwise 1.
    function automatic int lane_width(input int w);
        return (w >= 2 * LANE_BITS) ? 2 : 1;
    endfunction
endpackage

// File: rtl/shape_ram_inreg.sv
module shape_ram_inreg #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              stall,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANE_W-1:0] lane,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANE_W-1:0] lane_q,
    output logic              go_q
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANE_W-1:0] lane;
        logic              go;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d    = cap_q;
        cap_d.go = 1'b0;                  // a write is armed for one edge only
        if (ce) begin
            if (!stall) begin
                cap_d.addr = addr;
            end
            cap_d.data = wdata;
            cap_d.lane = lane;
            cap_d.go   = we;
        end
        if (rst) begin
            cap_d.addr = '0;
            cap_d.go   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign addr_q  = cap_q.addr;
    assign wdata_q = cap_q.data;
    assign lane_q  = cap_q.lane;
    assign go_q    = cap_q.go;

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(addr_q) && $stable(wdata_q)));
    p_stall_keeps_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (ce && stall) |=> $stable(addr_q));
    p_no_arm_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !ce |=> !go_q);
    p_arm_once_r6: assert property (@(posedge clk) disable iff (rst)
        (ce && we) |=> go_q);
endmodule

// File: rtl/shape_ram_array.sv
module shape_ram_array
    import shape_ram_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SLOTS     = ROW_W / DATA_W;
    localparam int SLOT_BITS = ADDR_W - ROW_AW;

    typedef struct packed {
        logic              en;
        logic [ROW_AW-1:0] row;
        logic [ROW_W-1:0]  val;
    } row_wr_t;

    logic [ROW_W-1:0]  mem_q [ROWS];
    logic [ROW_AW-1:0] row;
    logic [3:0]        slot;
    logic [ROW_W-1:0]  rd_row;
    logic [ROW_W-1:0]  slot_hit;
    logic [ROW_W-1:0]  lane_bits;
    logic [ROW_W-1:0]  wr_mask;
    row_wr_t           wr_d;

    // Upper address bits pick the row, lower ones the slot inside it.
    assign row = addr[ADDR_W-1 -: ROW_AW];

    generate
        if (SLOT_BITS == 0) begin : g_one_slot
            assign slot = '0;
        end else begin : g_slots
            assign slot = 4'(addr[SLOT_BITS-1:0]);
        end
    endgenerate

    generate
        if (DATA_W == 2 * LANE_BITS) begin : g_two_lanes
            assign lane_bits = {{LANE_BITS{lane[LANE_W-1]}}, {LANE_BITS{lane[0]}}};
            p_lane_keep_r5: assert property (@(posedge clk) disable iff (rst)
                (wr_go && !lane[LANE_W-1]) |=>
                (mem_q[$past(row)][ROW_W-1:LANE_BITS] == $past(mem_q[row][ROW_W-1:LANE_BITS])));
        end else if (DATA_W == LANE_BITS) begin : g_one_lane
            logic unused_rst;
            assign unused_rst = &{1'b0, rst};
            assign lane_bits  = {ROW_W{lane[0]}};
        end else begin : g_no_lanes
            logic unused_lane;
            assign unused_lane = &{1'b0, lane, rst};
            assign lane_bits   = '1;
        end
    endgenerate

    always_comb begin
        for (int b = 0; b < ROW_W; b++) begin
            slot_hit[b] = ((b / DATA_W) == int'(slot));
        end
    end

    assign rd_row  = mem_q[row];
    assign rd_data = rd_row[int'(slot) * DATA_W +: DATA_W];
    assign wr_mask = slot_hit & lane_bits;

    always_comb begin
        wr_d.en  = wr_go;
        wr_d.row = row;
        wr_d.val = (rd_row & ~wr_mask) | ({SLOTS{wdata}} & wr_mask);
    end

    always_ff @(posedge clk) begin
        if (wr_d.en) begin
            mem_q[wr_d.row] <= wr_d.val;
        end
    end
endmodule

// File: rtl/shape_ram_outreg.sv
module shape_ram_outreg #(
    parameter int DATA_W  = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [DATA_W-1:0] rd,
    output logic [DATA_W-1:0] dout
);
    generate
        if (OUT_REG) begin : g_reg
            logic [DATA_W-1:0] dout_d, dout_q;

            always_comb begin
                dout_d = ce ? rd : dout_q;
            end

            always_ff @(posedge clk) begin
                dout_q <= dout_d;
            end

            assign dout = dout_q;

            p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
                !ce |=> $stable(dout));
        end else begin : g_bypass
            logic unused_out;
            assign unused_out = &{1'b0, clk, ce, rst};
            assign dout       = rd;
        end
    endgenerate
endmodule

// File: rtl/shape_ram.sv
module shape_ram
    import shape_ram_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit OUT_REG = 1'b1,
    localparam int DEPTH  = TOTAL_BITS / DATA_W,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LANE_W = lane_width(DATA_W)
) (
    input  logic              in_clk,
    input  logic              rst,
    input  logic              in_ce,
    input  logic              stall,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANE_W-1:0] lane_en,
    input  logic              out_clk,
    input  logic              out_ce,
    output logic [DATA_W-1:0] rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANE_W-1:0] lane_q;
    logic              go_q;
    logic [DATA_W-1:0] rd_word;

    shape_ram_inreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_inreg (
        .clk(in_clk), .rst(rst), .ce(in_ce), .stall(stall), .we(we),
        .addr(addr), .wdata(wdata), .lane(lane_en),
        .addr_q(addr_q), .wdata_q(wdata_q), .lane_q(lane_q), .go_q(go_q)
    );

    shape_ram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
        .clk(in_clk), .rst(rst), .wr_go(go_q), .addr(addr_q),
        .wdata(wdata_q), .lane(lane_q), .rd_data(rd_word)
    );

    shape_ram_outreg #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_outreg (
        .clk(out_clk), .rst(rst), .ce(out_ce), .rd(rd_word), .dout(rdata)
    );
endmodule

// File: tb/sim_shape_ram.sv
module sim_shape_ram;
    logic        in_clk = 1'b0;
    logic        out_clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0, stall = 1'b0, we = 1'b0, oce = 1'b0;
    logic [9:0]  a = '0;
    logic [15:0] d = '0;
    logic [1:0]  ln = '0;
    logic [15:0] q0;
    logic [3:0]  q1;

    // u0: 16-bit shape with output register; u1: 4-bit shape, bypassed output.
    shape_ram #(.DATA_W(16), .OUT_REG(1'b1)) u0 (
        .in_clk(in_clk), .rst(rst), .in_ce(ce), .stall(stall), .we(we),
        .addr(a[7:0]), .wdata(d), .lane_en(ln), .out_clk(out_clk),
        .out_ce(oce), .rdata(q0)
    );
    shape_ram #(.DATA_W(4), .OUT_REG(1'b0)) u1 (
        .in_clk(in_clk), .rst(rst), .in_ce(ce), .stall(stall), .we(we),
        .addr(a), .wdata(d[3:0]), .lane_en(ln[0]), .out_clk(out_clk),
        .out_ce(oce), .rdata(q1)
    );

    // 125 MHz input clock; output clock 2 ns behind it.
    always #4 in_clk = ~in_clk;
    initial begin
        #6;
        forever begin
            out_clk = 1'b1; #4;
            out_clk = 1'b0; #4;
        end
    end

    logic [15:0] ref0 [256];
    logic [3:0]  ref1 [1024];
    int          h0 = 0, h1 = 0;
    logic [15:0] e0;
    logic [3:0]  e1;
    int          errs = 0, checks = 0;

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One input-clock operation; checks both instances after the edge.
    task automatic op(input logic r, input logic c, input logic s, input logic w,
                      input logic [9:0] ad, input logic [15:0] dd, input logic [1:0] l,
                      input logic o, input bit chk, input string tag);
        @(negedge in_clk);
        rst = r; ce = c; stall = s; we = w; a = ad; d = dd; ln = l; oce = o;
        if (r) begin
            h0 = 0; h1 = 0;
        end else if (c && !s) begin
            h0 = int'(ad[7:0]); h1 = int'(ad);
        end
        if (o) e0 = ref0[h0];
        e1 = ref1[h1];
        @(posedge in_clk);
        #3;
        if (chk) begin
            check(q0, e0, {tag, " u0"});
            check({12'h0, q1}, {12'h0, e1}, {tag, " u1"});
        end
        if (!r && c && w) begin
            if (l[0]) ref0[h0][7:0]  = dd[7:0];
            if (l[1]) ref0[h0][15:8] = dd[15:8];
            ref1[h1] = dd[3:0];
        end
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (60000) @(posedge in_clk);
        errs++; checks++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd17));
        for (int i = 0; i < 4; i++) op(1, 0, 0, 0, '0, '0, 2'b00, 1, 0, "");
        // Fill both memories, full lanes.
        for (int i = 0; i < 1024; i++)
            op(0, 1, 0, 1, 10'(i), 16'(i * 16'h0107 ^ 16'h5A3C), 2'b11, 1, 0, "");
        // R1: full read sweep.
        for (int i = 0; i < 1024; i++)
            op(0, 1, 0, 0, 10'(i), '0, 2'b00, 1, 1, "R1 read sweep");

        // R7: read-before-write, then read shows new data.
        op(0, 1, 0, 1, 10'd3, 16'hBEEF, 2'b11, 1, 1, "R7 old data during write");
        op(0, 1, 0, 0, 10'd3, 16'h0, 2'b00, 1, 1, "R7 new data after write");
        // R5: single-lane writes.
        op(0, 1, 0, 1, 10'd40, 16'h1234, 2'b01, 1, 1, "R5 low lane write");
        op(0, 1, 0, 0, 10'd40, 16'h0, 2'b00, 1, 1, "R5 upper lane kept");
        op(0, 1, 0, 1, 10'd41, 16'hABCD, 2'b10, 1, 1, "R5 high lane write");
        op(0, 1, 0, 0, 10'd41, 16'h0, 2'b00, 1, 1, "R5 lower lane kept");
        // R8: lanes off still write the whole narrow word.
        op(0, 1, 0, 1, 10'd42, 16'h000A, 2'b00, 1, 1, "R8 narrow write lanes off");
        op(0, 1, 0, 0, 10'd42, 16'h0, 2'b00, 1, 1, "R8 narrow word replaced");
        // R4: stall keeps address; write lands at held address.
        op(0, 1, 0, 0, 10'd10, 16'h0, 2'b00, 1, 1, "R4 capture address");
        op(0, 1, 1, 1, 10'd20, 16'h5555, 2'b11, 1, 1, "R4 stalled write");
        op(0, 1, 1, 0, 10'd20, 16'h0, 2'b00, 1, 1, "R4 held address read");
        op(0, 1, 0, 0, 10'd20, 16'h0, 2'b00, 1, 1, "R4 other word untouched");
        // R2: disabled edge does nothing.
        op(0, 0, 0, 1, 10'd30, 16'hAAAA, 2'b11, 1, 1, "R2 disabled edge");
        op(0, 1, 0, 0, 10'd30, 16'h0, 2'b00, 1, 1, "R2 no write");
        // R6: one write, no repeat with new data while idle.
        op(0, 1, 0, 1, 10'd60, 16'h0F0F, 2'b11, 1, 1, "R6 write");
        for (int i = 0; i < 3; i++)
            op(0, 0, 0, 1, 10'd60, 16'hFFFF, 2'b11, 1, 1, "R6 idle");
        op(0, 1, 0, 0, 10'd60, 16'h0, 2'b00, 1, 1, "R6 single write kept");
        // R3 / R9: output enable low holds u0, u1 follows.
        op(0, 1, 0, 0, 10'd70, 16'h0, 2'b00, 1, 1, "R3 R9 load");
        op(0, 1, 0, 0, 10'd71, 16'h0, 2'b00, 0, 1, "R3 R9 hold vs bypass");
        op(0, 1, 0, 0, 10'd72, 16'h0, 2'b00, 0, 1, "R3 R9 hold vs bypass");
        // R10: reset clears address, suppresses write.
        op(1, 1, 0, 1, 10'd50, 16'h7777, 2'b11, 1, 1, "R10 reset to address 0");
        op(0, 1, 0, 0, 10'd50, 16'h0, 2'b00, 1, 1, "R10 write suppressed");

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            bit c, s, w, o;
            c = ($urandom % 4) != 0;
            s = ($urandom % 5) == 0;
            w = ($urandom % 2) != 0;
            o = ($urandom % 5) != 0;
            op(0, c, s, w, 10'($urandom), 16'($urandom), 2'($urandom), o, 1,
               "R2 R3 R4 R5 R6 R7 R8 R9 random");
        end
        summary();
        $finish;
    end
endmodule